// File: doc/BRIEF.md
# Phase-Mapped Pixel Black Offset

This block corrects the black level of a raw sensor stream. Each pixel gets a signed offset, and the offset depends on the pixel's color class. The class is not fixed. It comes from a programmable 4×4 map that is addressed by the pixel's row phase and column phase. Both phases are the line and pixel positions within the frame, taken modulo 4. The bench and the control logic derive the two phases from the frame-start and line-start markers that travel with the stream.

There are four classes: red/yellow, green-on-red-row/cyan, green-on-blue-row/green, and blue/magenta. Each class has its own signed 8-bit offset. The sum of pixel and offset saturates at zero and at full scale, so it never wraps. When the stream is not raw sensor data, the raw-mode input is held low and pixels pass through unchanged. The phase tracking continues during pass-through, so correction can resume in the middle of a line. The corrected pixel appears one clock after it is presented.

Top module: `color_phase_offset`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `outValid` is 0 and `outData` is 0.
- R2: The map entry for a pixel is `classMap[2*i+1:2*i]` with i = row*4 + col. The class codes are 0 = R/Ye, 1 = Gr/Cy, 2 = Gb/G and 3 = B/Mg. The offset for class k is the two's-complement byte `offsetsIn[8*k+7:8*k]`, with a range from -128 to +127.
- R3: The column phase is 0 on a valid pixel that carries the line-start or frame-start marker. It increases by one, modulo 4, on each later valid pixel of the line.
- R4: The row phase is set as follows on each valid pixel:
  - With the frame-start marker, the row phase is 0.
  - With the line-start marker and no frame-start marker, it is the previous row phase plus one, modulo 4.
  - With neither marker, it is held.
- R5: In raw mode the output is pixel + offset, clamped to the range 0 to 2^PIX_W-1.
- R6: `outValid` equals `pixValid` of the previous cycle. `outData` holds its value after a cycle with no valid pixel.
- R7: With `rawMode` low, a valid pixel is output unchanged. The phase counters still advance, so correction resumes at the right phase when `rawMode` returns high.
- R8: Markers and data presented while `pixValid` is low change neither the output nor the phase counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rawMode | input | 1 | 1 = apply the offset; 0 = pass pixels through |
| classMap | input | 32 | 16 two-bit class codes, entry row*4+col |
| offsetsIn | input | 32 | Four signed 8-bit offsets, class k in byte k |
| pixValid | input | 1 | Pixel present this cycle |
| pixLineStart | input | 1 | Pixel is the first of a line |
| pixFrameStart | input | 1 | Pixel is the first of a frame |
| pixData | input | PIX_W | Raw pixel value |
| outValid | output | 1 | Corrected pixel present |
| outData | output | PIX_W | Corrected pixel value |

## Verification
Two row updates can fall on the same pixel: the row reset from frame start and the row step from line start. Every frame's first pixel carries both markers, and the check is that the row phase returns to 0 instead of advancing. Line lengths that are not multiples of four make the column wrap and the row step land on different phases from line to line. Idle cycles that carry stray markers sit between pixels, and the bench judges them against its own position model.

// File: rtl/cpo_pkg.sv
package cpo_pkg;
  localparam int PHASES  = 4;
  localparam int PHASE_W = $clog2(PHASES);
  localparam int CLASSES = 4;
  localparam int CLASS_W = $clog2(CLASSES);

  // Strobes handed from the phase control to the offset datapath.
  typedef struct packed {
    logic               sample;
    logic               bypass;
    logic [PHASE_W-1:0] row;
    logic [PHASE_W-1:0] col;
  } phaseStrobe_t;
endpackage

// File: rtl/cpo_phase_ctrl.sv
module cpo_phase_ctrl
  import cpo_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rawMode,
  input  logic         pixValid,
  input  logic         pixLineStart,
  input  logic         pixFrameStart,
  output phaseStrobe_t strobe
);
  logic [PHASE_W-1:0] pixCnt;
  logic [PHASE_W-1:0] lineCnt;
  logic [PHASE_W-1:0] rowNow;
  logic [PHASE_W-1:0] colNow;

  // Frame start wins over line start on the same pixel.
  always_comb begin
    rowNow = lineCnt;
    colNow = pixCnt;
    if (pixFrameStart) begin
      rowNow = '0;
      colNow = '0;
    end else if (pixLineStart) begin
      rowNow = lineCnt + PHASE_W'(1);
      colNow = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixCnt  <= '0;
      lineCnt <= '0;
    end else if (pixValid) begin
      pixCnt  <= colNow + PHASE_W'(1);
      lineCnt <= rowNow;
    end
  end

  assign strobe.sample = pixValid;
  assign strobe.bypass = !rawMode;
  assign strobe.row    = rowNow;
  assign strobe.col    = colNow;

  p_col_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !pixLineStart && !pixFrameStart) |=> pixCnt == $past(pixCnt) + PHASE_W'(1));

  p_row_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixLineStart && !pixFrameStart) |=> lineCnt == $past(lineCnt) + PHASE_W'(1));

  p_idle_markers_r8: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> ($stable(pixCnt) && $stable(lineCnt)));
endmodule

// File: rtl/cpo_offset_path.sv
module cpo_offset_path
  import cpo_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int OFF_W = 8
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  phaseStrobe_t                         strobe,
  input  logic [PIX_W-1:0]                     pixData,
  input  logic [PHASES*PHASES*CLASS_W-1:0]     classMap,
  input  logic [CLASSES*OFF_W-1:0]             offsetsIn,
  output logic                                 outValid,
  output logic [PIX_W-1:0]                     outData
);
  localparam int ENTRIES = PHASES * PHASES;
  localparam int SUM_W   = ((PIX_W > OFF_W) ? PIX_W : OFF_W) + 2;
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  logic [CLASS_W-1:0] mapEntry [ENTRIES];
  logic [OFF_W-1:0]   offEntry [CLASSES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_map
    assign mapEntry[g] = classMap[g*CLASS_W +: CLASS_W];
  end
  for (genvar k = 0; k < CLASSES; k++) begin : g_off
    assign offEntry[k] = offsetsIn[k*OFF_W +: OFF_W];
  end

  logic [CLASS_W-1:0]      pixClass;
  logic [OFF_W-1:0]        selOff;
  logic signed [SUM_W-1:0] sumVal;
  logic [PIX_W-1:0]        clamped;
  logic [PIX_W-1:0]        corrected;

  always_comb begin
    pixClass = mapEntry[{strobe.row, strobe.col}];
    selOff   = offEntry[pixClass];
    sumVal   = $signed({{(SUM_W-PIX_W){1'b0}}, pixData})
             + $signed({{(SUM_W-OFF_W){selOff[OFF_W-1]}}, selOff});
    if (sumVal[SUM_W-1])
      clamped = '0;
    else if (|sumVal[SUM_W-2:PIX_W])
      clamped = PIX_MAX;
    else
      clamped = sumVal[PIX_W-1:0];
    corrected = strobe.bypass ? pixData : clamped;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strobe.sample;
      if (strobe.sample) outData <= corrected;
    end
  end

  p_offset_up_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sample && !strobe.bypass && !selOff[OFF_W-1]) |=> outData >= $past(pixData));

  p_offset_down_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sample && !strobe.bypass && selOff[OFF_W-1]) |=> outData <= $past(pixData));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.sample |=> $stable(outData));
endmodule

// File: rtl/color_phase_offset.sv
module color_phase_offset
  import cpo_pkg::*;
#(
  parameter int PIX_W = 12,
  parameter int OFF_W = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             rawMode,
  input  logic [PHASES*PHASES*CLASS_W-1:0] classMap,
  input  logic [CLASSES*OFF_W-1:0]         offsetsIn,
  input  logic                             pixValid,
  input  logic                             pixLineStart,
  input  logic                             pixFrameStart,
  input  logic [PIX_W-1:0]                 pixData,
  output logic                             outValid,
  output logic [PIX_W-1:0]                 outData
);
  phaseStrobe_t strobe;

  cpo_phase_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .rawMode       (rawMode),
    .pixValid      (pixValid),
    .pixLineStart  (pixLineStart),
    .pixFrameStart (pixFrameStart),
    .strobe        (strobe)
  );

  cpo_offset_path #(.PIX_W(PIX_W), .OFF_W(OFF_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pixData   (pixData),
    .classMap  (classMap),
    .offsetsIn (offsetsIn),
    .outValid  (outValid),
    .outData   (outData)
  );

  p_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> outValid);

  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !outValid);

  p_bypass_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !rawMode) |=> outData == $past(pixData));
endmodule

// File: tb/color_phase_offset_bench.sv
`timescale 1ns/1ps
module color_phase_offset_bench;
  localparam int PIX_W = 12;
  localparam int OFF_W = 8;
  localparam int PMAX  = (1 << PIX_W) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rstN;
  logic             rawMode;
  logic [31:0]      classMap;
  logic [31:0]      offsetsIn;
  logic             pixValid, pixLineStart, pixFrameStart;
  logic [PIX_W-1:0] pixData;
  logic             outValid;
  logic [PIX_W-1:0] outData;

  color_phase_offset #(.PIX_W(PIX_W), .OFF_W(OFF_W)) u_color_phase_offset (
    .clk(clk), .rstN(rstN), .rawMode(rawMode), .classMap(classMap),
    .offsetsIn(offsetsIn), .pixValid(pixValid), .pixLineStart(pixLineStart),
    .pixFrameStart(pixFrameStart), .pixData(pixData),
    .outValid(outValid), .outData(outData)
  );

  int compared   = 0;
  int mismatched = 0;
  int mRow = 0;
  int mCol = 0;
  logic [PIX_W-1:0] expData = '0;

  function automatic logic [31:0] buildMap(int kind);
    logic [31:0] m;
    m = '0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        int cls;
        cls = (kind == 0) ? (r + c) % 4 : (r * 3 + c * c + kind) % 4;
        m[(r*4+c)*2 +: 2] = 2'(cls);
      end
    return m;
  endfunction

  function automatic logic [31:0] packOffsets(int o0, int o1, int o2, int o3);
    return {8'(o3), 8'(o2), 8'(o1), 8'(o0)};
  endfunction

  task automatic compare(string tag, logic aV, logic eV, logic [PIX_W-1:0] aD, logic [PIX_W-1:0] eD);
    compared++;
    if (aV !== eV || aD !== eD) begin
      mismatched++;
      $display("FAIL %s actual valid=%0b data=%0d expected valid=%0b data=%0d",
               tag, aV, aD, eV, eD);
    end
  endtask

  // One clock: drive at the falling edge, check after the next rising edge.
  task automatic step(logic v, logic ls, logic fs, logic [PIX_W-1:0] d);
    string tag;
    pixValid = v; pixLineStart = ls; pixFrameStart = fs; pixData = d;
    tag = "R6 R8";
    if (v) begin
      int row, col, cls, off, sum;
      // R3 R4: independent position model
      if (fs)      begin row = 0; col = 0; end
      else if (ls) begin row = (mRow + 1) % 4; col = 0; end
      else         begin row = mRow; col = mCol; end
      mRow = row;
      mCol = (col + 1) % 4;
      cls = int'(classMap[(row*4+col)*2 +: 2]);
      off = int'($signed(offsetsIn[cls*8 +: 8]));
      sum = int'(d) + off;
      tag = "R2 R3 R4";
      if (!rawMode) begin
        sum = int'(d);
        tag = "R7";
      end else if (sum < 0) begin
        sum = 0; tag = "R5";
      end else if (sum > PMAX) begin
        sum = PMAX; tag = "R5";
      end
      expData = PIX_W'(sum);
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag, outValid, v, outData, expData);
  endtask

  task automatic runStream(int p0, int nPix, int lineLen, int linesPerFrame, int gapEvery, int mul);
    for (int p = p0; p < p0 + nPix; p++) begin
      int pos, line;
      pos  = p % lineLen;
      line = (p / lineLen) % linesPerFrame;
      if (p % gapEvery == gapEvery - 1)
        step(1'b0, 1'b1, 1'b1, PIX_W'(p * 7 + 3));
      step(1'b1, pos == 0, (pos == 0) && (line == 0), PIX_W'((p * mul) % (PMAX + 1)));
    end
  endtask

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; rawMode = 1'b1;
    classMap = buildMap(0);
    offsetsIn = packOffsets(-128, 127, -1, 1);
    pixValid = 1'b0; pixLineStart = 1'b0; pixFrameStart = 1'b0; pixData = '0;
    repeat (3) @(negedge clk);
    compare("R1", outValid, 1'b0, outData, '0);
    rstN = 1'b1;
    @(negedge clk);
    compare("R1", outValid, 1'b0, outData, '0);

    // Every pixel value across all classes, extreme offsets (clamps both ends).
    runStream(0, 4096, 24, 8, 7, 1);

    // Odd line length and six lines so column and row wrap on shifting phases.
    classMap  = buildMap(1);
    offsetsIn = packOffsets(37, -90, 0, 64);
    runStream(0, 2048, 5, 6, 11, 173);

    // Pass-through mid-line, then correction resumes on tracked phase.
    classMap  = buildMap(2);
    offsetsIn = packOffsets(-20, 100, -128, 127);
    rawMode = 1'b0;
    runStream(0, 101, 9, 5, 13, 41);
    rawMode = 1'b1;
    runStream(101, 300, 9, 5, 13, 41);

    // Idle cycles with stray markers, then continue the line.
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 12'hFFF);
    runStream(401, 40, 9, 5, 100, 41);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule